// File: doc/BRIEF.md
# Latched Second-Level Interrupt Controller

This block collects up to 32 peripheral interrupt lines and presents one request line to a parent interrupt controller. Each source has one bit in every register. A per-source mask gates which pending sources may drive the request. Software reads the pending sources and the mask, and changes the mask without a read-modify-write: one register sets mask bits and another clears them, each acting only on the bits written as 1.

A build-time parameter selects one of two variants. The edge variant passes each input through a two-flop synchronizer and catches each rising edge in a sticky status bit. Software acknowledges a pending bit by writing 1 to it in a clear register. The level variant shows the synchronized input levels directly in the status register. It has no clear register, and its mask registers sit at lower offsets. A simple register port carries the accesses: address, write enable, write data, and combinational read data.

Top module: `irq_l2_latch`

## Requirements
- R1: After reset every mask bit is 1, every status bit is 0 and `irq_o` is low.
- R2: A write of 1s to the mask-set register (offset 0x10 in edge mode, 0x08 in level mode) masks those sources. Bits written as 0 keep their mask value.
- R3: A write of 1s to the mask-clear register (offset 0x14 in edge mode, 0x0C in level mode) unmasks those sources. Bits written as 0 keep their mask value.
- R4: The mask-status register reads the current mask, with 1 meaning masked. It is at offset 0x0C in edge mode and 0x04 in level mode. The status register is at offset 0x00 in both modes, and bit i belongs to source i.
- R5: In edge mode a 0-to-1 transition of a synchronized input sets its status bit. The bit stays set after the input falls.
- R6: In edge mode, writing 1 to a bit of the clear register (offset 0x08) clears that status bit. Bits written as 0 leave their status bit unchanged.
- R7: In edge mode, when a new rising edge and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: In level mode each status bit follows its synchronized input level and drops when the input deasserts.
- R9: `irq_o` is high exactly when some status bit is 1 and its mask bit is 0. A masked source still shows in the status register.
- R10: Reads of offsets with no register, and of the clear, mask-set and mask-clear registers, return 0. Writes to offsets with no register change nothing. In level mode, offsets 0x10 and 0x14 are among those with no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Peripheral interrupt lines, one per source |
| bus_addr | input | AW | Register byte offset |
| bus_we | input | 1 | Write strobe, acts at the rising clock edge |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Request to the parent controller |

## Verification
The bench goes after these corner cases:
- Every source position is swept in both variants. A design with a mis-wired bit or a wrong offset would report the event at the wrong place.
- An acknowledge is timed to land in the same cycle as a new edge on the same bit. A design that lets the clear win would lose that event.
- Zero-valued writes to the set, clear and acknowledge registers are checked to change nothing. A design that treats these registers as plain stores would wipe the mask or the status.
- The level variant receives writes to the edge-only offsets. A decoder that ignores the mode parameter would change state on those writes.

// File: rtl/irq_l2_latch.sv
module irq_l2_latch #(
  parameter int NSRC = 32,
  parameter int AW = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_STAT = AW'(8'h00);
  localparam logic [AW-1:0] A_ACK  = AW'(8'h08);
  localparam logic [AW-1:0] A_MST  = EDGE_MODE ? AW'(8'h0C) : AW'(8'h04);
  localparam logic [AW-1:0] A_MSET = EDGE_MODE ? AW'(8'h10) : AW'(8'h08);
  localparam logic [AW-1:0] A_MCLR = EDGE_MODE ? AW'(8'h14) : AW'(8'h0C);

  logic [NSRC-1:0] sync1, sync2, prev, rise, status, mask_q;
  logic            wr_ack, wr_mset, wr_mclr;

  assign wr_ack  = EDGE_MODE && bus_we && (bus_addr == A_ACK);
  assign wr_mset = bus_we && (bus_addr == A_MSET);
  assign wr_mclr = bus_we && (bus_addr == A_MCLR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
      prev  <= sync2;
    end

  assign rise = EDGE_MODE ? (sync2 & ~prev) : '0;

  generate
    if (EDGE_MODE) begin : g_edge
      logic [NSRC-1:0] latched;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) latched <= '0;
        else        latched <= (latched & ~(wr_ack ? bus_wdata : '0)) | rise;
      assign status = latched;
    end else begin : g_level
      assign status = sync2;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= '1;
    else if (wr_mset) mask_q <= mask_q | bus_wdata;
    else if (wr_mclr) mask_q <= mask_q & ~bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_STAT)     bus_rdata = status;
    else if (bus_addr == A_MST) bus_rdata = mask_q;
  end

  assign irq_o = |(status & ~mask_q);
endmodule

module irq_l2_latch_chk #(
  parameter int NSRC = 32,
  parameter int AW = 8,
  parameter bit EDGE_MODE = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] rise,
  input logic            irq_o
);
  localparam logic [AW-1:0] C_ACK  = AW'(8'h08);
  localparam logic [AW-1:0] C_MSET = EDGE_MODE ? AW'(8'h10) : AW'(8'h08);
  localparam logic [AW-1:0] C_MCLR = EDGE_MODE ? AW'(8'h14) : AW'(8'h0C);

  p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (&mask_q));

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_MSET) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == C_MCLR) |=> ((mask_q & $past(bus_wdata)) == '0));

  // R2 and R3: the mask only moves on its own strobes
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == C_MSET || bus_addr == C_MCLR)) |=> $stable(mask_q));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (EDGE_MODE && !(bus_we && bus_addr == C_ACK)) |=> (($past(status) & ~status) == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (EDGE_MODE && rise != '0) |=> ((status & $past(rise)) == $past(rise)));

  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_o);
endmodule

bind irq_l2_latch irq_l2_latch_chk #(.NSRC(NSRC), .AW(AW), .EDGE_MODE(EDGE_MODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .mask_q(mask_q), .status(status), .rise(rise), .irq_o(irq_o)
);

// File: tb/irq_l2_latch_bench.sv
`timescale 1ns/1ps
module irq_l2_latch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [7:0]  e_addr = '0, l_addr = '0;
  logic        e_we = 1'b0, l_we = 1'b0;
  logic [31:0] e_wd = '0, l_wd = '0, e_rd, l_rd;
  logic        e_irq, l_irq;
  int nchk = 0, nfail = 0;

  always #2 clk = ~clk;

  irq_l2_latch #(.NSRC(32), .AW(8), .EDGE_MODE(1'b1)) u_irq_l2_latch (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(e_addr), .bus_we(e_we),
    .bus_wdata(e_wd), .bus_rdata(e_rd), .irq_o(e_irq));

  irq_l2_latch #(.NSRC(32), .AW(8), .EDGE_MODE(1'b0)) u_irq_l2_latch_lvl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(l_addr), .bus_we(l_we),
    .bus_wdata(l_wd), .bus_rdata(l_rd), .irq_o(l_irq));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit lvl, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    if (lvl) begin l_addr = a; l_wd = d; l_we = 1'b1; end
    else     begin e_addr = a; e_wd = d; e_we = 1'b1; end
    @(negedge clk);
    l_we = 1'b0; e_we = 1'b0;
  endtask

  task automatic rd(input bit lvl, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    if (lvl) l_addr = a; else e_addr = a;
    #0.5;
    d = lvl ? l_rd : e_rd;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, em, lm, es;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(0, 8'h00, d); check("R1 edge status", d, 0);
    rd(0, 8'h0C, d); check("R1 edge mask", d, 32'hFFFF_FFFF);
    rd(1, 8'h04, d); check("R1 level mask", d, 32'hFFFF_FFFF);
    check("R1 irq", {30'd0, e_irq, l_irq}, 0);
    // R10 write-only and undefined offsets read zero
    rd(0, 8'h08, d); check("R10 ack reads 0", d, 0);
    rd(0, 8'h10, d); check("R10 mset reads 0", d, 0);
    rd(0, 8'h14, d); check("R10 mclr reads 0", d, 0);
    rd(0, 8'h04, d); check("R10 edge hole reads 0", d, 0);
    rd(1, 8'h08, d); check("R10 level mset reads 0", d, 0);
    rd(1, 8'h10, d); check("R10 level hole reads 0", d, 0);
    // R10 writes to holes ignored
    wr(0, 8'h18, 32'h0000_FFFF); wr(0, 8'h04, 32'h0000_FFFF);
    rd(0, 8'h0C, d); check("R10 edge hole write", d, 32'hFFFF_FFFF);
    wr(1, 8'h14, 32'hFFFF_FFFF); wr(1, 8'h10, 32'h0000_00FF);
    rd(1, 8'h04, d); check("R10 level hole write", d, 32'hFFFF_FFFF);
    // R2 R3 R4 mask set/clear arithmetic
    em = 32'hFFFF_FFFF; lm = em;
    wr(0, 8'h14, 32'h0000_FFFF); em &= ~32'h0000_FFFF;
    wr(1, 8'h0C, 32'h0000_FFFF); lm &= ~32'h0000_FFFF;
    rd(0, 8'h0C, d); check("R3 edge mclr", d, em);
    rd(1, 8'h04, d); check("R3 level mclr", d, lm);
    wr(0, 8'h10, 32'h0000_0F00); em |= 32'h0000_0F00;
    wr(1, 8'h08, 32'h0000_0F00); lm |= 32'h0000_0F00;
    rd(0, 8'h0C, d); check("R2 edge mset", d, em);
    rd(1, 8'h04, d); check("R4 level mask readback", d, lm);
    wr(0, 8'h10, 0); wr(0, 8'h14, 0); wr(1, 8'h08, 0); wr(1, 8'h0C, 0);
    rd(0, 8'h0C, d); check("R2 R3 zero writes edge", d, em);
    rd(1, 8'h04, d); check("R2 R3 zero writes level", d, lm);
    wr(0, 8'h14, 32'h8000_0000); em &= ~32'h8000_0000;
    wr(1, 8'h0C, 32'h0001_0000); lm &= ~32'h0001_0000;
    rd(0, 8'h0C, d); check("R3 edge single", d, em);
    rd(1, 8'h04, d); check("R3 level single", d, lm);
    // per-source sweep, R5 R6 R8 R9
    for (int i = 0; i < 32; i++) begin
      src = 32'd1 << i;
      settle();
      rd(0, 8'h00, d); check($sformatf("R5 edge latch bit %0d", i), d, 32'd1 << i);
      check($sformatf("R9 edge irq bit %0d", i), {31'd0, e_irq}, {31'd0, ~em[i]});
      rd(1, 8'h00, d); check($sformatf("R8 level follow bit %0d", i), d, 32'd1 << i);
      check($sformatf("R9 level irq bit %0d", i), {31'd0, l_irq}, {31'd0, ~lm[i]});
      src = '0;
      settle();
      rd(0, 8'h00, d); check($sformatf("R5 sticky bit %0d", i), d, 32'd1 << i);
      rd(1, 8'h00, d); check($sformatf("R8 level drop bit %0d", i), d, 0);
      wr(0, 8'h08, 32'd0); 
      rd(0, 8'h00, d); check($sformatf("R6 zero ack bit %0d", i), d, 32'd1 << i);
      wr(0, 8'h08, 32'd1 << i);
      rd(0, 8'h00, d); check($sformatf("R6 ack bit %0d", i), d, 0);
      check($sformatf("R9 irq idle bit %0d", i), {31'd0, e_irq}, 0);
    end
    // multi-bit pattern, masked still visible R9
    src = 32'hA5A5_0F0F; es = src;
    settle();
    rd(0, 8'h00, d); check("R5 multi latch", d, es);
    check("R9 multi irq", {31'd0, e_irq}, {31'd0, |(es & ~em)});
    rd(1, 8'h00, d); check("R8 multi level", d, es);
    wr(0, 8'h10, 32'hFFFF_FFFF); wr(1, 8'h08, 32'hFFFF_FFFF);
    rd(0, 8'h00, d); check("R9 masked visible", d, es);
    check("R9 masked no irq", {30'd0, e_irq, l_irq}, 0);
    wr(0, 8'h14, 32'h0000_0001);
    check("R9 one unmasked", {31'd0, e_irq}, 1);
    wr(0, 8'h08, 32'h0000_0F0F); es &= ~32'h0000_0F0F;
    rd(0, 8'h00, d); check("R6 partial ack", d, es);
    check("R9 after ack", {31'd0, e_irq}, 0);
    src = '0; settle();
    wr(0, 8'h08, 32'hFFFF_FFFF);
    rd(0, 8'h00, d); check("R6 ack all", d, 0);
    // R7 same-cycle edge and ack
    @(negedge clk); src = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk); e_addr = 8'h08; e_wd = 32'h0000_0020; e_we = 1'b1;
    @(negedge clk); e_we = 1'b0;
    rd(0, 8'h00, d); check("R7 set wins", d, 32'h0000_0020);
    wr(0, 8'h08, 32'h0000_0020);
    rd(0, 8'h00, d); check("R7 later ack clears", d, 0);
    src = '0; settle();
    summary();
    $finish;
  end
endmodule